// File: doc/BRIEF.md
# Three-Phase Decimating FIR Low-Pass Filter

This block takes a stream of signed samples and returns a low-pass filtered stream at one third of the input rate. The nine-tap prototype response is split into three phase subfilters of three taps each. Within any one subfilter the taps it uses are three apart in the prototype. Samples are taken strictly in arrival order. A phase counter steps on every accepted sample, and each sample goes to the subfilter of its phase. One bank of three multipliers is shared by all phases. The phase counter picks which three coefficients feed that bank.

Each subfilter is built in transposed form. The new sample drives all three of its taps at once, and the partial sums wait in registers that sit between the adders. An accumulator loads the contribution of the first phase of a frame, adds the second, and adds the third. It then saturates the total to the output width and presents it together with a one-cycle strobe. Coefficients are written at run time through a small address/data write port.

Top module: `poly_decim3`

## Requirements
- R1: A synchronous active-high reset clears every partial-sum register, the accumulator, the phase counter and all nine coefficients. After reset `out_valid` and `out_data` are 0, and the first output is computed with zero history.
- R2: The phase counter advances only on cycles where `in_valid` is high, and it wraps to phase 0 after phase 2. Sample number n after reset, counting from 0, therefore has phase n mod 3, however many idle cycles lie between samples.
- R3: `out_valid` is high for exactly one cycle: the cycle after the clock edge that accepts a phase-2 sample. It is low at all other times.
- R4: The output issued for the frame that ends with sample n (n mod 3 = 2) is sum over k = 0..8 of h[k]·x[n−k]. Samples before reset count as zero, and h[0] weights the newest sample. Input samples and coefficients are 8-bit two's complement.
- R5: Cycles with `in_valid` low leave the filter state untouched, so a stream with gaps gives the same outputs as the same stream without gaps.
- R6: The full-precision sum is saturated to the 16-bit signed range [−32768, 32767] before it is output.
- R7: A write with `coef_we` high and `coef_addr` = k (0..8) sets h[k] to `coef_data`. A sample uses the coefficients held at the clock edge that accepts it. Products already stored in the partial sums keep the coefficients they were formed with.
- R8: A coefficient write whose address is 9 or more changes no coefficient.
- R9: Between strobes, `out_data` holds the last output value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient index h[k] |
| coef_data | input | 8 | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe per decimated output |
| out_data | output | 16 | Saturated signed decimated output |

## Verification
A phase counter that slips, or that steps on idle cycles, moves the strobe away from every third accepted sample. It also changes which coefficients weight which samples, and both effects show on the very next output. A wrong partial-sum register or a wrong coefficient routing corrupts only the outputs whose nine-sample window covers the affected sample. Single impulses at each of the three phase positions are used so that every tap is isolated within three outputs. Faulty saturation shows only in frames that are driven to full scale, so both extremes are exercised on purpose.

// File: rtl/poly_decim_pkg.sv
package poly_decim_pkg;

    localparam int PD_DATA_W = 8;
    localparam int PD_COEF_W = 8;
    localparam int PD_OUT_W  = 16;
    localparam int PD_DECIM  = 3;
    localparam int PD_TPP    = 3;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_EMIT = 2'd2
    } acc_op_e;

    function automatic acc_op_e phase_to_op(input int phase, input int decim);
        if (phase == decim - 1)
            return ACC_EMIT;
        else if (phase == 0)
            return ACC_LOAD;
        else
            return ACC_ADD;
    endfunction

endpackage

// File: rtl/pd3_phase_seq.sv
module pd3_phase_seq
    import poly_decim_pkg::*;
#(
    parameter int DECIM = PD_DECIM,
    parameter int PH_W  = $clog2(DECIM)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic [PH_W-1:0] phase,
    output acc_op_e         op
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(DECIM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (in_valid) begin
            if (phase == LAST_PH)
                phase <= '0;
            else
                phase <= phase + 1'b1;
        end
    end

    always_comb begin
        op = phase_to_op(int'(phase), DECIM);
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < DECIM);                                   // R2
    AST_PHASE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase));                          // R2

endmodule

// File: rtl/pd3_coef_bank.sv
module pd3_coef_bank
    import poly_decim_pkg::*;
#(
    parameter int COEF_W = PD_COEF_W,
    parameter int DECIM  = PD_DECIM,
    parameter int TPP    = PD_TPP,
    parameter int TAPS   = DECIM * TPP,
    parameter int AW     = $clog2(TAPS),
    parameter int PH_W   = $clog2(DECIM)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [COEF_W-1:0]           wr_data,
    input  logic [PH_W-1:0]             phase,
    output logic [TPP-1:0][COEF_W-1:0]  sel_coef
);

    logic [TAPS-1:0][COEF_W-1:0] bank;
    logic                        addr_ok;

    assign addr_ok = int'(wr_addr) < TAPS;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (wr_en && addr_ok) begin
            bank[wr_addr] <= wr_data;
        end
    end

    // Subfilter for phase p, tap i, uses prototype index (DECIM-1-p) + DECIM*i
    for (genvar i = 0; i < TPP; i++) begin : g_sel
        logic [AW-1:0] idx;
        always_comb begin
            idx = AW'((DECIM - 1 - int'(phase)) + DECIM * i);
            sel_coef[i] = bank[idx];
        end
    end

    AST_COEF_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_ok) |=> $stable(bank));                 // R8

endmodule

// File: rtl/pd3_subfilter.sv
module pd3_subfilter
    import poly_decim_pkg::*;
#(
    parameter int TPP    = PD_TPP,
    parameter int PROD_W = PD_DATA_W + PD_COEF_W,
    parameter int ACC_W  = PROD_W + 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [TPP-1:0][PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]    part
);

    // Transposed chain: stage[i] holds the pending sum for tap i.
    logic signed [ACC_W-1:0] stage [1:TPP];
    logic signed [ACC_W-1:0] ext   [0:TPP-1];

    for (genvar i = 0; i < TPP; i++) begin : g_ext
        assign ext[i] = ACC_W'($signed(prod[i]));
    end

    assign stage[TPP] = '0;

    for (genvar i = 1; i < TPP; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= '0;
            else if (en)
                stage[i] <= ext[i] + stage[i+1];
        end
    end

    assign part = ext[0] + stage[1];

endmodule

// File: rtl/pd3_frame_acc.sv
module pd3_frame_acc
    import poly_decim_pkg::*;
#(
    parameter int ACC_W = 21,
    parameter int OUT_W = PD_OUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  acc_op_e                 op,
    input  logic signed [ACC_W-1:0] part,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);

    localparam logic signed [ACC_W-1:0] SAT_HI =
        $signed({{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] SAT_LO =
        $signed({{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] total;
    logic [OUT_W-1:0]        clipped;

    assign total = acc + part;

    always_comb begin
        if (total > SAT_HI)
            clipped = SAT_HI[OUT_W-1:0];
        else if (total < SAT_LO)
            clipped = SAT_LO[OUT_W-1:0];
        else
            clipped = total[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                unique case (op)
                    ACC_LOAD: acc <= part;
                    ACC_ADD:  acc <= total;
                    ACC_EMIT: begin
                        acc       <= '0;
                        out_data  <= clipped;
                        out_valid <= 1'b1;
                    end
                    default:  acc <= acc;
                endcase
            end
        end
    end

    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);                              // R3
    AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && op == ACC_EMIT));       // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));                      // R9

endmodule

// File: rtl/poly_decim3.sv
module poly_decim3
    import poly_decim_pkg::*;
#(
    parameter int DATA_W = PD_DATA_W,
    parameter int COEF_W = PD_COEF_W,
    parameter int OUT_W  = PD_OUT_W,
    parameter int DECIM  = PD_DECIM,
    parameter int TPP    = PD_TPP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              coef_we,
    input  logic [3:0]        coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    localparam int TAPS   = DECIM * TPP;
    localparam int AW     = $clog2(TAPS);
    localparam int PH_W   = $clog2(DECIM);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS) + 1;

    logic [PH_W-1:0]                 phase;
    acc_op_e                         op;
    logic [TPP-1:0][COEF_W-1:0]      coef_sel;
    logic [TPP-1:0][PROD_W-1:0]      prod_bus;
    logic [DECIM-1:0][ACC_W-1:0]     sub_part;
    logic signed [ACC_W-1:0]         active_part;

    pd3_phase_seq #(.DECIM(DECIM), .PH_W(PH_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .phase    (phase),
        .op       (op)
    );

    pd3_coef_bank #(
        .COEF_W (COEF_W), .DECIM (DECIM), .TPP (TPP),
        .TAPS   (TAPS),   .AW    (AW),    .PH_W (PH_W)
    ) u_coef (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (coef_we),
        .wr_addr  (AW'(coef_addr)),
        .wr_data  (coef_data),
        .phase    (phase),
        .sel_coef (coef_sel)
    );

    // Shared multiplier bank: one product per tap of the active phase
    for (genvar i = 0; i < TPP; i++) begin : g_mul
        logic signed [PROD_W-1:0] p;
        assign p = $signed(in_data) * $signed(coef_sel[i]);
        assign prod_bus[i] = p;
    end

    for (genvar ph = 0; ph < DECIM; ph++) begin : g_sub
        logic                    en;
        logic signed [ACC_W-1:0] part;
        assign en = in_valid && (int'(phase) == ph);
        pd3_subfilter #(.TPP(TPP), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_sub (
            .clk  (clk),
            .rst  (rst),
            .en   (en),
            .prod (prod_bus),
            .part (part)
        );
        assign sub_part[ph] = part;
    end

    always_comb begin
        active_part = '0;
        for (int ph = 0; ph < DECIM; ph++) begin
            if (int'(phase) == ph)
                active_part = $signed(sub_part[ph]);
        end
    end

    pd3_frame_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .part      (active_part),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: tb/poly_decim3_tb_top.sv
module poly_decim3_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic [7:0]  coef_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;

    int xs [0:1023];
    int hs [0:1023][0:8];
    int cur_h [0:8];
    int n = 0;
    int last_out = 0;

    always #5 clk = ~clk;

    poly_decim3 dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int expect_at(input int idx);
        int s = 0;
        for (int k = 0; k < 9; k++)
            if (idx - k >= 0) s += hs[idx-k][k] * xs[idx-k];
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        coef_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n = 0;
        last_out = 0;
        for (int k = 0; k < 9; k++) cur_h[k] = 0;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_data == 16'd0, "R1 out_data after reset", int'(out_data), 0);
    endtask

    task automatic wr_coef(input int addr, input int val);
        coef_we = 1'b1;
        coef_addr = addr[3:0];
        coef_data = val[7:0];
        @(posedge clk);
        @(negedge clk);
        coef_we = 1'b0;
        if (addr < 9) cur_h[addr] = val;
    endtask

    task automatic send(input int x);
        in_valid = 1'b1;
        in_data = x[7:0];
        xs[n] = x;
        for (int k = 0; k < 9; k++) hs[n][k] = cur_h[k];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (n % 3 == 2) begin
            int e = expect_at(n);
            check(out_valid == 1'b1, "R3 strobe on third sample", int'(out_valid), 1);
            check($signed(out_data) == e, "R4 output value", int'($signed(out_data)), e);
            last_out = e;
        end else begin
            check(out_valid == 1'b0, "R3 no strobe mid-frame", int'(out_valid), 0);
            check($signed(out_data) == last_out, "R9 output held", int'($signed(out_data)), last_out);
        end
        n++;
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R5 no strobe while idle", int'(out_valid), 0);
            check($signed(out_data) == last_out, "R9 output held idle", int'($signed(out_data)), last_out);
        end
    endtask

    task automatic load_set(input int sel);
        for (int k = 0; k < 9; k++)
            wr_coef(k, (sel == 0) ? (k * 13 - 50) : (((k * 29 + 7) % 200) - 100));
    endtask

    task automatic t_zero_history();   // R1
        do_reset();
        for (int i = 0; i < 6; i++) send(100 - i * 37);
    endtask

    task automatic t_impulse(input int pos);   // R4 tap spacing per phase
        do_reset();
        load_set(0);
        for (int i = 0; i < 15; i++) send((i == pos) ? 3 : 0);
    endtask

    task automatic t_gaps();   // R2 R5
        do_reset();
        load_set(1);
        for (int i = 0; i < 30; i++) begin
            send(((i * 71 + 19) % 256) - 128);
            if (i % 4 == 1) idle(i % 3 + 1);
        end
    endtask

    task automatic t_saturate();   // R6
        do_reset();
        for (int k = 0; k < 9; k++) wr_coef(k, -128);
        for (int i = 0; i < 12; i++) send(-128);
        check(last_out == 32767, "R6 positive clip", last_out, 32767);
        for (int k = 0; k < 9; k++) wr_coef(k, 127);
        for (int i = 0; i < 12; i++) send(-128);
        check(last_out == -32768, "R6 negative clip", last_out, -32768);
    endtask

    task automatic t_bad_addr();   // R8
        do_reset();
        load_set(0);
        wr_coef(9, 77);
        wr_coef(15, -90);
        wr_coef(12, 5);
        for (int i = 0; i < 12; i++) send(i * 11 - 60);
    endtask

    task automatic t_midstream();   // R7
        do_reset();
        load_set(1);
        for (int i = 0; i < 20; i++) begin
            send(((i * 53 + 3) % 256) - 128);
            if (i == 4) wr_coef(2, 99);
            if (i == 9) wr_coef(7, -77);
            if (i == 13) wr_coef(0, 45);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_zero_history();
        t_impulse(0);
        t_impulse(1);
        t_impulse(2);
        t_gaps();
        t_saturate();
        t_bad_addr();
        t_midstream();
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule